// File: doc/BRIEF.md
# Bit-Serial Receive FIFO with Level Interrupt

This block buffers demodulated receive data one bit at a time and hands it to a host over a serial link. Each received bit arrives with a one-cycle strobe and is appended to a circular bit store of `DEPTH` entries. The host can drain the store in one of two ways. In the first, it holds a dedicated active-low select line low and toggles its serial clock: the oldest bit is presented on `sdo`, and each falling edge of the host clock removes one bit. In the second, it issues a one-cycle read command that moves the oldest bit into a register. An interrupt flag stays high while the number of stored bits is at or above a programmable level. With the level set to 1, this means "data present", so a host keeps reading until the flag drops.

The host select and host clock are asynchronous to the reference clock `clk`. Each passes through a `SYNC_STAGES` synchronizer before edge detection, so the host clock must run below a quarter of the reference clock. A controller state machine has three states. In `ST_OFF` the buffer is disabled and held empty. In `ST_RUN` it is enabled and the command read is accepted. In `ST_DIRECT` it is enabled with the select line low, and the host clock shifts data out. The transitions are:
- enable (`ST_OFF`→`ST_RUN`)
- select-low (`ST_RUN`→`ST_DIRECT`)
- select-high (`ST_DIRECT`→`ST_RUN`)
- disable (`ST_RUN`/`ST_DIRECT`→`ST_OFF`)

Two pin-function outputs are multiplexed by the enable input. When the buffer is disabled, they carry the raw receive bit and the raw receive clock. When it is enabled, they carry the buffer readout and the interrupt.

Sticky status bits record an overflow and any change of the interrupt flag. A one-cycle status read clears both. A bit that arrives while the store is full, with no read in the same cycle, is dropped.

Top module: `rxbit_fifo`

## Requirements
- R1: After reset, and at every disable-to-enable transition, the stored bit count is 0 and `fifo_int` is low; the controller holds the count at 0 for as long as `fifo_en` is low.
- R2: While enabled, a high `rx_strobe` at a clock edge stores `rx_bit` and raises `bit_count` by one. While disabled, strobes are ignored and `bit_count` stays 0.
- R3: `fifo_int` is high exactly when the buffer is enabled and `bit_count` >= the effective level. The effective level equals `int_level`, except that a level of 0 counts as 1.
- R4: In the direct state (`host_sel_n` low after synchronization), `sdo` shows the oldest stored bit. Each falling edge of `host_sck` removes one bit, so bits leave in arrival order.
- R5: `host_sck` edges while `host_sel_n` is high remove no bits.
- R6: A one-cycle `cmd_pop` in the run state loads the oldest bit into `cmd_bit` and removes it from the store. On an empty store it changes nothing and `bit_count` stays 0.
- R7: A strobe that arrives while `bit_count` equals `DEPTH`, with no read in the same cycle, is dropped. The stored bits and the count stay unchanged, and sticky `stat_over` is set. A one-cycle `stat_rd` clears `stat_over`.
- R8: Any change of `fifo_int` sets sticky `stat_thr_chg` one cycle later. `stat_rd` clears it.
- R9: A store and a read in the same cycle leave `bit_count` unchanged and keep the arrival order, even when the store is full.
- R10: With `fifo_en` low, `pin_data` follows `rx_bit` and `pin_clk` follows `rx_dclk`. With `fifo_en` high, `pin_data` carries `sdo` and `pin_clk` carries `fifo_int`.
- R11: `stat_empty` is high exactly when `bit_count` is 0. `stat_full` is high exactly when `bit_count` equals `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Buffer enable; also selects the pin functions |
| int_level | input | LVL_W | Interrupt level (0 acts as 1) |
| rx_bit | input | 1 | Demodulated receive bit |
| rx_strobe | input | 1 | One-cycle valid strobe for `rx_bit` |
| rx_dclk | input | 1 | Raw receive data clock (bypass path) |
| host_sel_n | input | 1 | Direct-read select, active low, asynchronous |
| host_sck | input | 1 | Host serial clock, asynchronous |
| cmd_pop | input | 1 | One-cycle command read request |
| stat_rd | input | 1 | One-cycle status read; clears the sticky bits |
| sdo | output | 1 | Oldest stored bit while in the direct state, else 0 |
| fifo_int | output | 1 | Level interrupt |
| cmd_bit | output | 1 | Bit returned by the last command read |
| bit_count | output | $clog2(DEPTH+1) | Number of stored bits |
| stat_over | output | 1 | Sticky overflow flag |
| stat_thr_chg | output | 1 | Sticky interrupt-change flag |
| stat_empty | output | 1 | Store empty |
| stat_full | output | 1 | Store full |
| pin_data | output | 1 | Pin function: raw data or buffer readout |
| pin_clk | output | 1 | Pin function: raw data clock or interrupt |

## Verification
The bench builds the block with its default parameters: a depth of 16, a 4-bit level field and two synchronizer stages. With a 16-bit store, a full buffer, the drop of an extra bit, and the full-with-read case can each be reached in a few dozen cycles. The 4-bit level covers the special level 0, the minimum level 1, and the maximum level 15, right beside depth 16. Two synchronizer stages fix the latency of the host clock and select at three reference cycles, so the bench can pace the host clock at eight cycles per period and still see every edge.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    // Controller states of the receive bit buffer
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_RUN    = 2'd1,
        ST_DIRECT = 2'd2
    } rxf_state_e;

endpackage

// File: rtl/rxf_sync.sv
// Multi-stage synchronizer for one asynchronous host line.
module rxf_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/rxf_bitstore.sv
// Circular bit store with occupancy count.
module rxf_bitstore #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic          din,
    input  logic          pop,
    output logic          head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          drop
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DEPTH-1:0] mem_q;
    logic [AW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;
    logic             wr_ok, rd_ok;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign rd_ok = pop & ~empty;
    assign wr_ok = push & (~full | rd_ok);
    assign drop  = push & full & ~rd_ok;
    assign head  = mem_q[rp_q];
    assign count = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (wr_ok && !clear) begin
            mem_q[wp_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_ok) wp_q <= ptr_next(wp_q);
            if (rd_ok) rp_q <= ptr_next(rp_q);
            unique case ({wr_ok, rd_ok})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R7: occupancy never passes the depth
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R7: a push into a full store without a read leaves it full
    p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clear) |=> full);

    // R9: simultaneous store and read keep the count
    p_pushpop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !clear) |=> $stable(count));

    // R4: a lone read removes exactly one bit
    p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty && !clear) |=> (count == $past(count) - CW'(1)));

    // R1: clearing empties the store
    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty);

endmodule

// File: rtl/rxf_ctrl.sv
// Controller: mode state machine, read paths, interrupt and status.
module rxf_ctrl
    import rxf_pkg::*;
#(
    parameter int CW          = 5,
    parameter int LW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [LW-1:0] level,
    input  logic          rx_strobe,
    input  logic          host_sel_n,
    input  logic          host_sck,
    input  logic          cmd_pop,
    input  logic          stat_rd,
    input  logic [CW-1:0] count,
    input  logic          head,
    input  logic          drop,
    output logic          clear,
    output logic          push,
    output logic          pop,
    output logic          sdo,
    output logic          int_o,
    output logic          cmd_bit,
    output logic          stat_over,
    output logic          stat_thr_chg
);

    rxf_state_e state_q, state_d;
    logic       sel_s, sck_s, sck_prev_q, sck_fell;
    logic       int_prev_q, over_q, thr_q, cmd_bit_q;
    logic       store_empty, cmd_take;
    logic [LW-1:0] lvl_eff;

    rxf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
        .clk(clk), .rst_n(rst_n), .async_in(host_sel_n), .sync_out(sel_s));

    rxf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .async_in(host_sck), .sync_out(sck_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= sck_s;
    end
    assign sck_fell = sck_prev_q & ~sck_s;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    if (fifo_en) state_d = ST_RUN;
            ST_RUN: begin
                if (!fifo_en)    state_d = ST_OFF;
                else if (!sel_s) state_d = ST_DIRECT;
            end
            ST_DIRECT: begin
                if (!fifo_en)   state_d = ST_OFF;
                else if (sel_s) state_d = ST_RUN;
            end
            default:   state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Outputs derived from the state
    always_comb begin
        store_empty = (count == '0);
        lvl_eff     = (level == '0) ? LW'(1) : level;
        clear       = 1'b0;
        push        = 1'b0;
        pop         = 1'b0;
        cmd_take    = 1'b0;
        sdo         = 1'b0;
        int_o       = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                clear = 1'b1;
            end
            ST_RUN: begin
                push     = rx_strobe;
                cmd_take = cmd_pop & ~store_empty;
                pop      = cmd_take;
                int_o    = (count >= CW'(lvl_eff));
            end
            ST_DIRECT: begin
                push  = rx_strobe;
                pop   = sck_fell & ~store_empty;
                sdo   = head;
                int_o = (count >= CW'(lvl_eff));
            end
            default: clear = 1'b1;
        endcase
    end

    // Status and command-read registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_prev_q <= 1'b0;
            over_q     <= 1'b0;
            thr_q      <= 1'b0;
            cmd_bit_q  <= 1'b0;
        end else begin
            int_prev_q <= int_o;
            if (cmd_take) cmd_bit_q <= head;
            if (stat_rd) begin
                over_q <= 1'b0;
                thr_q  <= 1'b0;
            end
            if (drop)                over_q <= 1'b1;
            if (int_o != int_prev_q) thr_q  <= 1'b1;
        end
    end

    assign cmd_bit      = cmd_bit_q;
    assign stat_over    = over_q;
    assign stat_thr_chg = thr_q;

    // R8: the change flag holds until a status read
    p_thr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_q && !stat_rd) |=> thr_q);

    // R5: nothing leaves the store while the select line is high
    p_no_pop_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !cmd_pop) |-> !pop);

    // R1: the disabled state empties the store by the next edge
    p_off_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> (count == '0));

    // R2: disabled state never stores a bit
    p_off_nopush_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> !push);

endmodule

// File: rtl/rxbit_fifo.sv
// Bit-serial receive FIFO with level interrupt and pin-function mux.
module rxbit_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int LVL_W       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] int_level,
    input  logic             rx_bit,
    input  logic             rx_strobe,
    input  logic             rx_dclk,
    input  logic             host_sel_n,
    input  logic             host_sck,
    input  logic             cmd_pop,
    input  logic             stat_rd,
    output logic             sdo,
    output logic             fifo_int,
    output logic             cmd_bit,
    output logic [CW-1:0]    bit_count,
    output logic             stat_over,
    output logic             stat_thr_chg,
    output logic             stat_empty,
    output logic             stat_full,
    output logic             pin_data,
    output logic             pin_clk
);

    logic clear, push, pop, head, drop;

    rxf_bitstore #(.DEPTH(DEPTH), .CW(CW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .push  (push),
        .din   (rx_bit),
        .pop   (pop),
        .head  (head),
        .count (bit_count),
        .full  (stat_full),
        .empty (stat_empty),
        .drop  (drop)
    );

    rxf_ctrl #(.CW(CW), .LW(LVL_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en      (fifo_en),
        .level        (int_level),
        .rx_strobe    (rx_strobe),
        .host_sel_n   (host_sel_n),
        .host_sck     (host_sck),
        .cmd_pop      (cmd_pop),
        .stat_rd      (stat_rd),
        .count        (bit_count),
        .head         (head),
        .drop         (drop),
        .clear        (clear),
        .push         (push),
        .pop          (pop),
        .sdo          (sdo),
        .int_o        (fifo_int),
        .cmd_bit      (cmd_bit),
        .stat_over    (stat_over),
        .stat_thr_chg (stat_thr_chg)
    );

    assign pin_data = fifo_en ? sdo      : rx_bit;
    assign pin_clk  = fifo_en ? fifo_int : rx_dclk;

    // R3: the interrupt never signals an empty store
    p_int_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_int |-> !stat_empty);

    // R7: overflow only rises after a full store
    p_ovf_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_over) |-> $past(stat_full));

    // R11: empty and full are never both high
    p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_empty && stat_full));

endmodule

// File: tb/rxbit_fifo_bench.sv
module rxbit_fifo_bench;

    localparam int DEPTH = 16;
    localparam int LVL_W = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    // {level, bits to store, expected interrupt}
    localparam int VEC [9][3] = '{
        '{1, 0, 0}, '{1, 1, 1}, '{0, 1, 1}, '{0, 0, 0}, '{4, 3, 0},
        '{4, 4, 1}, '{15, 14, 0}, '{15, 15, 1}, '{2, 16, 1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 1'b0;
    logic [LVL_W-1:0] int_level = '0;
    logic rx_bit = 1'b0, rx_strobe = 1'b0, rx_dclk = 1'b0;
    logic host_sel_n = 1'b1, host_sck = 1'b0, cmd_pop = 1'b0, stat_rd = 1'b0;
    logic sdo, fifo_int, cmd_bit, stat_over, stat_thr_chg, stat_empty, stat_full;
    logic pin_data, pin_clk;
    logic [CW-1:0] bit_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rxbit_fifo #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_rxbit_fifo (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .int_level(int_level),
        .rx_bit(rx_bit), .rx_strobe(rx_strobe), .rx_dclk(rx_dclk),
        .host_sel_n(host_sel_n), .host_sck(host_sck), .cmd_pop(cmd_pop),
        .stat_rd(stat_rd), .sdo(sdo), .fifo_int(fifo_int), .cmd_bit(cmd_bit),
        .bit_count(bit_count), .stat_over(stat_over), .stat_thr_chg(stat_thr_chg),
        .stat_empty(stat_empty), .stat_full(stat_full),
        .pin_data(pin_data), .pin_clk(pin_clk)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_bit(input logic b);
        rx_bit = b; rx_strobe = 1'b1;
        tick(1);
        rx_strobe = 1'b0;
    endtask

    task automatic sck_pulse();
        host_sck = 1'b1; tick(4);
        host_sck = 1'b0; tick(4);
    endtask

    task automatic cmd_read();
        cmd_pop = 1'b1; tick(1); cmd_pop = 1'b0;
    endtask

    task automatic status_read();
        stat_rd = 1'b1; tick(1); stat_rd = 1'b0;
    endtask

    task automatic restart();
        fifo_en = 1'b0; tick(2);
        fifo_en = 1'b1; tick(1);
    endtask

    function automatic logic pat(input int k);
        return logic'((k ^ (k >> 2)) & 1);
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 / R11: reset state
        chk("R1 count after reset", bit_count, 0);
        chk("R1 int after reset", fifo_int, 0);
        chk("R11 empty after reset", stat_empty, 1);
        // R10: bypass pins while disabled
        rx_bit = 1'b1; rx_dclk = 1'b1; #1;
        chk("R10 pin_data bypass", pin_data, 1);
        chk("R10 pin_clk bypass", pin_clk, 1);
        // R2: strobes ignored while disabled
        push_bit(1'b1); push_bit(1'b0);
        chk("R2 disabled push ignored", bit_count, 0);
        // R10: enabled pin functions
        fifo_en = 1'b1; rx_dclk = 1'b1; rx_bit = 1'b1; tick(1);
        chk("R10 pin_clk is int", pin_clk, 0);
        chk("R10 pin_data is sdo", pin_data, 0);

        // Table walk: R2 and R3
        for (int v = 0; v < 9; v++) begin
            restart();
            int_level = LVL_W'(VEC[v][0]);
            for (int k = 0; k < VEC[v][1]; k++) push_bit(pat(k));
            #1;
            chk($sformatf("R2 count vec%0d", v), bit_count, VEC[v][1]);
            chk($sformatf("R3 int vec%0d", v), fifo_int, VEC[v][2]);
            chk($sformatf("R11 full vec%0d", v), stat_full, (VEC[v][1] == DEPTH) ? 1 : 0);
        end

        // R4: direct read order, level 1 flags data present
        restart();
        int_level = 4'd1;
        push_bit(1); push_bit(0); push_bit(1); push_bit(1); push_bit(0);
        host_sel_n = 1'b0; tick(4);
        begin
            logic [4:0] exp_bits;
            exp_bits = 5'b01101;
            for (int k = 0; k < 5; k++) begin
                chk($sformatf("R4 sdo bit%0d", k), sdo, exp_bits[k]);
                chk($sformatf("R10 pin_data bit%0d", k), pin_data, exp_bits[k]);
                chk($sformatf("R3 int while data %0d", k), fifo_int, 1);
                sck_pulse();
            end
        end
        chk("R4 count after drain", bit_count, 0);
        chk("R3 int after drain", fifo_int, 0);
        host_sel_n = 1'b1; tick(4);

        // R5: host clock ignored while deselected
        push_bit(1); push_bit(0); push_bit(1);
        sck_pulse(); sck_pulse();
        chk("R5 count with sck deselected", bit_count, 3);

        // R6: command read
        restart();
        push_bit(1); push_bit(0);
        cmd_read();
        chk("R6 cmd_bit first", cmd_bit, 1);
        chk("R6 count after first", bit_count, 1);
        cmd_read();
        chk("R6 cmd_bit second", cmd_bit, 0);
        chk("R6 count after second", bit_count, 0);
        cmd_read();
        chk("R6 empty read count", bit_count, 0);
        chk("R11 empty flag", stat_empty, 1);

        // R7: overflow drop and status clear
        restart();
        status_read();
        for (int k = 0; k < DEPTH; k++) push_bit(pat(k));
        chk("R11 full flag", stat_full, 1);
        chk("R7 no overflow yet", stat_over, 0);
        push_bit(~pat(0));
        chk("R7 count after drop", bit_count, DEPTH);
        chk("R7 overflow set", stat_over, 1);
        status_read();
        chk("R7 overflow cleared", stat_over, 0);
        for (int k = 0; k < DEPTH; k++) begin
            cmd_read();
            chk($sformatf("R7 kept bit%0d", k), cmd_bit, pat(k));
        end

        // R8: interrupt change flag
        restart();
        status_read();
        int_level = 4'd2;
        push_bit(1); tick(1);
        chk("R8 no change below level", stat_thr_chg, 0);
        push_bit(1); tick(1);
        chk("R8 change flagged", stat_thr_chg, 1);
        status_read();
        chk("R8 flag cleared", stat_thr_chg, 0);

        // R9: simultaneous store and read
        restart();
        push_bit(1); push_bit(0); push_bit(1);
        rx_bit = 1'b0; rx_strobe = 1'b1; cmd_pop = 1'b1;
        tick(1);
        rx_strobe = 1'b0; cmd_pop = 1'b0;
        chk("R9 count unchanged", bit_count, 3);
        chk("R9 cmd_bit oldest", cmd_bit, 1);
        cmd_read(); chk("R9 order 1", cmd_bit, 0);
        cmd_read(); chk("R9 order 2", cmd_bit, 1);
        cmd_read(); chk("R9 order 3", cmd_bit, 0);

        // R9 at full: no drop
        restart();
        status_read();
        for (int k = 0; k < DEPTH; k++) push_bit(pat(k));
        rx_bit = 1'b1; rx_strobe = 1'b1; cmd_pop = 1'b1;
        tick(1);
        rx_strobe = 1'b0; cmd_pop = 1'b0;
        chk("R9 full count kept", bit_count, DEPTH);
        chk("R9 full no overflow", stat_over, 0);
        for (int k = 1; k < DEPTH; k++) cmd_read();
        cmd_read();
        chk("R9 full last bit", cmd_bit, 1);

        // R1: re-enable clears stored bits
        int_level = 4'd1;
        push_bit(1); push_bit(1);
        restart();
        chk("R1 restart count", bit_count, 0);
        chk("R1 restart int", fifo_int, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule